// File: doc/BRIEF.md
# I2C SCL Clock Divider

This block turns a clock-control word and a rise/fall compensation count into the SCL waveform timing for an I2C master engine. The peripheral clock is first divided by (CDF+1) to give an internal clock, shown as a one-cycle tick. One SCL period lasts 20 + 8×SCGD + RND internal-clock ticks. That period is split into a low phase followed by a high phase. The low phase gets the extra tick when the period is odd.

The master engine raises `en_i` to run the clock and drops it to stop. Software picks CDF so that the internal clock stays below 20 MHz. It picks SCGD as the smallest step count whose SCL frequency does not exceed the target, and it supplies RND, the rounded product of the internal clock and the sum of the fall time, rise time and internal delay. The block takes a new control word only at an SCL period boundary, so a period never mixes two settings.

The control logic is a three-state machine. IDLE holds SCL high. On start (IDLE with `en_i` high) it loads the settings and moves to LOW. On half (the last tick of LOW) it moves to HIGH. On wrap (the last tick of HIGH with `en_i` high) it reloads the settings and returns to LOW. On stop (the last tick of HIGH with `en_i` low) it returns to IDLE.

Top module: `scl_clk_div`

## Requirements
- R1: After reset `scl_o` is 1, `busy_o` is 0 and `tick_o` is 0.
- R2: While idle with `en_i` low, changes on `ccr_i` and `rnd_i` have no effect: `scl_o` stays 1, `busy_o` stays 0 and no tick is produced.
- R3: While running, `tick_o` pulses once every CDF+1 clock cycles, where CDF is `ccr_i[2:0]`. A phase of N ticks therefore lasts N×(CDF+1) clock cycles.
- R4: One SCL period lasts P = 20 + 8×SCGD + RND ticks, where SCGD is `ccr_i[8:3]` and RND is `rnd_i`.
- R5: The low phase lasts ceil(P/2) ticks and the high phase lasts floor(P/2) ticks.
- R6: In the first cycle after a start, `busy_o` is 1 and `scl_o` is 0, so every period begins with its low phase.
- R7: `ccr_i` and `rnd_i` are sampled only at a start or a wrap. A change in the middle of a period does not alter that period.
- R8: When `en_i` falls, the current period runs to the end of its high phase. After that `busy_o` returns to 0 and `scl_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run request from the master engine |
| ccr_i | input | 9 | Clock control word: [2:0] prescale CDF, [8:3] step count SCGD |
| rnd_i | input | 6 | Rise/fall compensation count RND, in internal ticks |
| scl_o | output | 1 | SCL level to drive (0 during the low phase) |
| tick_o | output | 1 | Internal clock enable, one cycle wide |
| busy_o | output | 1 | High while an SCL period is in progress |

## Verification
The bench measures every low and high phase, both in clock cycles and in ticks, for settings that run from the shortest period with no prescale up to a long period with prescale 7 chosen by a field-selection model. It also covers an odd period length with the largest compensation count. A design that split odd periods the wrong way, or miscounted the base, the step or the prescale, would report phase lengths that are off by one tick or by a whole multiple. The control word is changed in the middle of a low phase and `en_i` is dropped mid-period. A design that loaded settings without waiting for a boundary would show a mixed-length period, and one that stopped early would cut the final high phase short. Changes to the inputs while idle must leave SCL quiet.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } scl_state_e;

    localparam int unsigned SCL_BASE_TICKS = 20;
    localparam int unsigned SCL_STEP_TICKS = 8;
endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
    parameter int unsigned CDF_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             run_i,
    input  logic [CDF_W-1:0] cdf_i,
    output logic             tick_o
);
    logic [CDF_W-1:0] cdf_q;
    logic [CDF_W-1:0] pcnt_q;

    assign tick_o = run_i && (pcnt_q == cdf_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cdf_q  <= '0;
            pcnt_q <= '0;
        end else if (load_i) begin
            cdf_q  <= cdf_i;
            pcnt_q <= '0;
        end else if (run_i) begin
            pcnt_q <= (pcnt_q == cdf_q) ? '0 : pcnt_q + 1'b1;
        end else begin
            pcnt_q <= '0;
        end
    end

    // R3: with a prescale above zero, two ticks never fall in back-to-back cycles
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && cdf_q != '0 && run_i && !load_i) |=> !tick_o);
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_div_pkg::*;
#(
    parameter int unsigned SCGD_W = 6,
    parameter int unsigned RND_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              tick_i,
    input  logic [SCGD_W-1:0] scgd_i,
    input  logic [RND_W-1:0]  rnd_i,
    output logic              load_o,
    output logic              run_o,
    output logic              scl_o
);
    localparam int unsigned MAX_PER = SCL_BASE_TICKS + SCL_STEP_TICKS * ((1 << SCGD_W) - 1)
                                    + ((1 << RND_W) - 1);
    localparam int unsigned PER_W   = $clog2(MAX_PER + 1);

    scl_state_e       state_q, state_d;
    logic [PER_W-1:0] per_w, low_w, high_w;
    logic [PER_W-1:0] low_q, high_q, cnt_q, cur_len;
    logic             last_tick, phase_end;

    assign per_w  = PER_W'(SCL_BASE_TICKS) + PER_W'(SCL_STEP_TICKS) * PER_W'(scgd_i) + PER_W'(rnd_i);
    assign high_w = per_w >> 1;
    assign low_w  = per_w - high_w;

    assign cur_len   = (state_q == ST_HIGH) ? high_q : low_q;
    assign last_tick = (cnt_q == cur_len - 1'b1);
    assign phase_end = tick_i && last_tick && (state_q != ST_IDLE);
    assign load_o    = ((state_q == ST_IDLE) && en_i)
                    || ((state_q == ST_HIGH) && phase_end && en_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (en_i)     state_d = ST_LOW;
            ST_LOW:  if (phase_end) state_d = ST_HIGH;
            ST_HIGH: if (phase_end) state_d = en_i ? ST_LOW : ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_q  <= PER_W'(1);
            high_q <= PER_W'(1);
            cnt_q  <= '0;
        end else begin
            if (load_o) begin
                low_q  <= low_w;
                high_q <= high_w;
            end
            if (load_o || phase_end || state_q == ST_IDLE) cnt_q <= '0;
            else if (tick_i)                               cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        run_o = (state_q != ST_IDLE);
        scl_o = (state_q != ST_LOW);
    end

    // R4: the tick count inside a phase stays below that phase's length
    a_r4_cnt_in_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (cnt_q < cur_len));
    // R5: a low phase is always followed by a high phase
    a_r5_low_then_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOW) |=> (state_q == ST_LOW || state_q == ST_HIGH));
    // R7: latched phase lengths move only at a start or a wrap
    a_r7_len_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_o) |=> ($stable(low_q) && $stable(high_q)));
    // R8: the idle state is reached only from the end of a high phase
    a_r8_idle_after_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && $past(state_q) != ST_IDLE) |-> ($past(state_q) == ST_HIGH));
endmodule

// File: rtl/scl_clk_div.sv
module scl_clk_div #(
    parameter int unsigned CDF_W  = 3,
    parameter int unsigned SCGD_W = 6,
    parameter int unsigned RND_W  = 6,
    localparam int unsigned CCR_W = CDF_W + SCGD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CCR_W-1:0] ccr_i,
    input  logic [RND_W-1:0] rnd_i,
    output logic             scl_o,
    output logic             tick_o,
    output logic             busy_o
);
    logic load_w, run_w, tick_w;

    scl_prescaler #(.CDF_W(CDF_W)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_w),
        .run_i  (run_w),
        .cdf_i  (ccr_i[CDF_W-1:0]),
        .tick_o (tick_w)
    );

    scl_phase_fsm #(.SCGD_W(SCGD_W), .RND_W(RND_W)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en_i),
        .tick_i (tick_w),
        .scgd_i (ccr_i[CCR_W-1:CDF_W]),
        .rnd_i  (rnd_i),
        .load_o (load_w),
        .run_o  (run_w),
        .scl_o  (scl_o)
    );

    assign tick_o = tick_w;
    assign busy_o = run_w;

    // R6: a start always enters the low phase
    a_r6_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && en_i) |=> (busy_o && !scl_o));
endmodule

// File: tb/scl_clk_div_tb.sv
module scl_clk_div_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0;
    logic [8:0] ccr_i = '0;
    logic [5:0] rnd_i = '0;
    logic       scl_o, tick_o, busy_o;

    int tests = 0;
    int fails = 0;
    int falls = 0;
    int idle_ticks = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;

    int q_lvl[$];
    int q_clk[$];
    int q_tck[$];

    always #10 clk = ~clk;

    scl_clk_div u_dut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .ccr_i(ccr_i), .rnd_i(rnd_i),
        .scl_o(scl_o), .tick_o(tick_o), .busy_o(busy_o)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // scoreboard driver side: push expected phases for n periods (R3 R4 R5)
    task automatic push_periods(input int cdf, input int scgd, input int rnd, input int n);
        int per, lo, hi;
        per = 20 + 8 * scgd + rnd;
        hi  = per / 2;
        lo  = per - hi;
        for (int i = 0; i < n; i++) begin
            q_lvl.push_back(0); q_clk.push_back(lo * (cdf + 1)); q_tck.push_back(lo);
            q_lvl.push_back(1); q_clk.push_back(hi * (cdf + 1)); q_tck.push_back(hi);
        end
    endtask

    task automatic set_cfg(input int cdf, input int scgd, input int rnd);
        ccr_i = 9'((scgd << 3) | cdf);
        rnd_i = 6'(rnd);
    endtask

    task automatic wait_falls(input int k);
        while (falls < k) @(negedge clk);
    endtask

    // field-selection model for software
    task automatic pick_fields(input longint rate, input longint target, input longint intd,
                               output int cdf, output int scgd, output int rnd);
        longint ick, r;
        cdf = int'(rate / 20000000);
        ick = rate / (cdf + 1);
        r   = ((ick + 500000) / 1000000) * (35 + 200 + intd);
        r   = (r + 500) / 1000;
        rnd = int'(r);
        scgd = 64;
        for (int s = 63; s >= 0; s--)
            if (ick / (20 + 8 * s + r) <= target) scgd = s;
    endtask

    // scoreboard monitor side
    int  m_lvl, m_len, m_tck;
    bit  was_busy = 1'b0;
    task automatic compare_phase();
        int el, ec, et;
        if (q_lvl.size() == 0) begin
            tests++; fails++;
            $display("FAIL R7: unexpected phase level %0d len %0d", m_lvl, m_len);
        end else begin
            el = q_lvl.pop_front(); ec = q_clk.pop_front(); et = q_tck.pop_front();
            check("R5 phase level", m_lvl, el);
            check("R4 R5 phase ticks", m_tck, et);
            check("R3 phase clocks", m_len, ec);
        end
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            if (!busy_o && tick_o) idle_ticks++;
            if (busy_o) begin
                if (!was_busy) begin
                    check("R6 first level", int'(scl_o), 0);
                    m_lvl = 0; m_len = 1; m_tck = int'(tick_o); falls++;
                end else if (int'(scl_o) == m_lvl) begin
                    m_len++; m_tck += int'(tick_o);
                end else begin
                    compare_phase();
                    if (!scl_o) falls++;
                    m_lvl = int'(scl_o); m_len = 1; m_tck = int'(tick_o);
                end
            end else if (was_busy) begin
                compare_phase();
            end
            was_busy = busy_o;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int c_cdf, c_scgd, c_rnd;
        repeat (3) @(negedge clk);
        check("R1 scl", int'(scl_o), 1);
        check("R1 busy", int'(busy_o), 0);
        check("R1 tick", int'(tick_o), 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        // R2: idle with changing settings
        for (int i = 0; i < 8; i++) begin
            set_cfg(i, i * 7, i * 5);
            repeat (5) @(negedge clk);
        end
        check("R2 scl idle", int'(scl_o), 1);
        check("R2 busy idle", int'(busy_o), 0);
        check("R2 idle ticks", idle_ticks, 0);

        pick_fields(64'd133333333, 64'd100000, 64'd5, c_cdf, c_scgd, c_rnd);
        check("R4 model cdf", c_cdf, 6);
        check("R4 model scgd", c_scgd, 21);

        set_cfg(0, 0, 0);
        push_periods(0, 0, 0, 3);
        en_i = 1'b1;
        wait_falls(3); repeat (3) @(negedge clk);
        set_cfg(1, 1, 5);              // R7: mid-period change
        push_periods(1, 1, 5, 2);
        wait_falls(5); repeat (3) @(negedge clk);
        set_cfg(c_cdf, c_scgd, c_rnd);
        push_periods(c_cdf, c_scgd, c_rnd, 2);
        wait_falls(7); repeat (3) @(negedge clk);
        set_cfg(3, 2, 63);
        push_periods(3, 2, 63, 1);
        wait_falls(8); repeat (3) @(negedge clk);
        en_i = 1'b0;                   // R8: drop mid-period
        check("R8 still busy", int'(busy_o), 1);
        while (busy_o) @(negedge clk);
        repeat (20) @(negedge clk);
        check("R8 scl after stop", int'(scl_o), 1);
        check("R8 busy after stop", int'(busy_o), 0);
        check("R7 queue drained", q_lvl.size(), 0);
        check("R2 no idle ticks", idle_ticks, 0);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule